// File: doc/BRIEF.md
# State-of-charge ranked carrier assignment for one converter arm

This block decides which submodule of a cascaded converter arm is driven by which level-shifted carrier. Under level-shifted PWM the lowest carrier keeps its submodule connected for the largest share of each period. The block ranks the arm's submodules by their state of charge and places the submodule that should move the most charge on the bottom carrier. The submodule that should move the least goes on the top carrier.

A request (`start`) takes a snapshot of the N state-of-charge words and of the current direction. The block then sorts the snapshot sequentially, one compare-exchange per clock. When the sort finishes it presents the new carrier map together with a one-cycle `done` pulse.

The current direction comes from a signed arm-current sample with a hysteresis band around zero. While the arm delivers energy, the fullest submodule sits at the bottom. While the arm absorbs energy, the rank is mirrored, so the emptiest submodule sits at the bottom. In this way the same cell discharges hardest and charges least.

Top module: `soc_carrier_ranker`

## Requirements
- R1: After reset `done` and `busy` are 0, the direction is "delivering", and the map is the identity: carrier c drives submodule c.
- R2: `start` is accepted only while `busy` is 0. `done` is then high for exactly one cycle, beginning N(N-1)/2+1 rising edges after the edge that samples `start`. The map changes in that same cycle.
- R3: `busy` is high from the edge after an accepted `start` until `done` rises. A `start` seen while `busy` is high is ignored, and it produces no extra `done`.
- R4: While delivering, carrier 0 drives the submodule with the highest state of charge, carrier 1 the next highest, and so on. Carrier 0 is the lowest carrier and sits at `carrier_map` bits [IDX_W-1:0]. Carrier c sits at bits [c*IDX_W +: IDX_W], and each field holds a submodule number.
- R5: While absorbing, the ranking of R4 is mirrored: the submodule of rank position i uses carrier N-1-i, so carrier 0 drives the lowest state of charge.
- R6: Equal state-of-charge values rank the lower submodule number first. Mirroring under R5 reverses that tie order as well.
- R7: If the arm-current sample is greater than +HYST, the direction becomes delivering. If it is less than -HYST, the direction becomes absorbing. Inside the band the previous direction is held. The direction used for a sort is the one held when `start` is accepted.
- R8: `carrier_map` is always a permutation: each submodule number appears in exactly one field.
- R9: `carrier_map` changes only in a `done` cycle. State-of-charge or current changes after `start` has been accepted do not affect that sort's result.
- R10: Each state-of-charge word is unsigned 16-bit fixed point in percent with 8 fractional bits (submodule k at `soc_in` bits [k*16 +: 16]), and the words are compared as unsigned numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new ranking |
| soc_in | input | N*SOC_W | Packed state-of-charge words, submodule 0 in the low bits |
| arm_cur | input | CUR_W | Signed arm-current sample, positive means delivering |
| busy | output | 1 | A ranking is in progress |
| done | output | 1 | One-cycle pulse: new map valid |
| carrier_map | output | N*IDX_W | Submodule number per carrier, carrier 0 (lowest) in the low bits |

## Verification
A wrong compare-exchange, or a corrupted rank register, shows up as a wrong field of `carrier_map` in the `done` cycle. Nothing leaks earlier, because the map is held between pulses. A miscounted step counter moves `done` by at least one cycle, and the per-cycle comparison against the reference model sees that at once. A wrong direction state stays hidden until the next accepted `start`, and then appears as a mirrored map.

// File: rtl/soc_rank_pkg.sv
package soc_rank_pkg;
   typedef enum logic {
      DIR_ABSORB  = 1'b0,
      DIR_DELIVER = 1'b1
   } arm_dir_e;

   function automatic int sort_steps(input int n);
      return n * (n - 1) / 2;
   endfunction
endpackage

// File: rtl/arm_dir_hyst.sv
module arm_dir_hyst
   import soc_rank_pkg::*;
#(
   parameter int CUR_W = 16,
   parameter int HYST  = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [CUR_W-1:0] arm_cur,
   output arm_dir_e                dir
);
   localparam logic signed [CUR_W-1:0] POS_TH = CUR_W'(HYST);
   localparam logic signed [CUR_W-1:0] NEG_TH = -CUR_W'(HYST);

   arm_dir_e dir_q;
   assign dir = dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                dir_q <= DIR_DELIVER;
      else if (arm_cur > POS_TH) dir_q <= DIR_DELIVER;
      else if (arm_cur < NEG_TH) dir_q <= DIR_ABSORB;
   end

   // R7
   dir_set_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_cur > POS_TH) |=> (dir == DIR_DELIVER));
   // R7
   dir_set_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_cur < NEG_TH) |=> (dir == DIR_ABSORB));
   // R7
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((arm_cur <= POS_TH) && (arm_cur >= NEG_TH)) |=> $stable(dir));
endmodule

// File: rtl/soc_rank_sorter.sv
module soc_rank_sorter
   import soc_rank_pkg::*;
#(
   parameter int N     = 4,
   parameter int SOC_W = 16,
   parameter int IDX_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  arm_dir_e             dir_in,
   input  logic [N*SOC_W-1:0]   soc_flat,
   output logic                 busy,
   output logic                 fin,
   output arm_dir_e             dir_snap,
   output logic [N*IDX_W-1:0]   rank_flat
);
   localparam int STEPS  = sort_steps(N);
   localparam int STEP_W = $clog2(STEPS + 1);
   localparam int PASS_W = $clog2(N) + 1;

   logic [SOC_W-1:0]  snap_q [N];
   logic [IDX_W-1:0]  rank_q [N];
   logic [IDX_W-1:0]  pos_q;
   logic [PASS_W-1:0] pass_q;
   logic [STEP_W-1:0] step_q;
   logic              busy_q;
   arm_dir_e          dir_q;

   logic [IDX_W-1:0]  pos_nx;
   logic [IDX_W-1:0]  lo_id, hi_id;
   logic              swap, last_in_pass;

   always_comb begin
      pos_nx       = IDX_W'(pos_q + 1'b1);
      lo_id        = rank_q[pos_q];
      hi_id        = rank_q[pos_nx];
      swap         = (snap_q[hi_id] > snap_q[lo_id]) ||
                     ((snap_q[hi_id] == snap_q[lo_id]) && (hi_id < lo_id));
      last_in_pass = (PASS_W'(pos_q) + pass_q) == PASS_W'(N - 2);
   end

   assign fin      = busy_q && (step_q == STEP_W'(STEPS));
   assign busy     = busy_q;
   assign dir_snap = dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= '0;
         pos_q  <= '0;
         pass_q <= '0;
         dir_q  <= DIR_DELIVER;
         for (int i = 0; i < N; i++) begin
            snap_q[i] <= '0;
            rank_q[i] <= IDX_W'(i);
         end
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            step_q <= '0;
            pos_q  <= '0;
            pass_q <= '0;
            dir_q  <= dir_in;
            for (int i = 0; i < N; i++) begin
               snap_q[i] <= soc_flat[i*SOC_W +: SOC_W];
               rank_q[i] <= IDX_W'(i);
            end
         end
      end else if (fin) begin
         busy_q <= 1'b0;
      end else begin
         if (swap) begin
            rank_q[pos_q]  <= hi_id;
            rank_q[pos_nx] <= lo_id;
         end
         step_q <= step_q + 1'b1;
         if (last_in_pass) begin
            pos_q  <= '0;
            pass_q <= pass_q + 1'b1;
         end else begin
            pos_q <= pos_nx;
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_rank_out
      assign rank_flat[g*IDX_W +: IDX_W] = rank_q[g];
   end

   // R2
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (step_q <= STEP_W'(STEPS)));
   // R3
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !fin) |=> busy_q);
   // R3
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (step_q == '0));
endmodule

// File: rtl/carrier_map_reg.sv
module carrier_map_reg
   import soc_rank_pkg::*;
#(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fin,
   input  arm_dir_e           dir,
   input  logic [N*IDX_W-1:0] rank_flat,
   output logic               done,
   output logic [N*IDX_W-1:0] map_flat
);
   logic [IDX_W-1:0] sel   [N];
   logic [IDX_W-1:0] map_q [N];
   logic             done_q;
   logic [N-1:0]     seen;

   for (genvar c = 0; c < N; c++) begin : g_carrier
      assign sel[c] = (dir == DIR_DELIVER) ? rank_flat[c*IDX_W +: IDX_W]
                                           : rank_flat[(N-1-c)*IDX_W +: IDX_W];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   map_q[c] <= IDX_W'(c);
         else if (fin) map_q[c] <= sel[c];
      end
      assign map_flat[c*IDX_W +: IDX_W] = map_q[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= fin;
   end
   assign done = done_q;

   always_comb begin
      seen = '0;
      for (int c = 0; c < N; c++) seen[map_q[c]] = 1'b1;
   end

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   perm_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      &seen);
   // R9
   map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(map_flat) |-> done);
endmodule

// File: rtl/soc_carrier_ranker.sv
module soc_carrier_ranker
   import soc_rank_pkg::*;
#(
   parameter int N     = 4,
   parameter int SOC_W = 16,
   parameter int CUR_W = 16,
   parameter int HYST  = 64,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [N*SOC_W-1:0]      soc_in,
   input  logic signed [CUR_W-1:0] arm_cur,
   output logic                    busy,
   output logic                    done,
   output logic [N*IDX_W-1:0]      carrier_map
);
   if (N < 2) begin : g_bad_n
      $error("soc_carrier_ranker: N must be at least 2");
   end
   if (IDX_W < $clog2(N)) begin : g_bad_idx
      $error("soc_carrier_ranker: IDX_W too narrow for N");
   end
   if (HYST < 0 || HYST >= (1 << (CUR_W - 1))) begin : g_bad_hyst
      $error("soc_carrier_ranker: HYST out of range for CUR_W");
   end

   arm_dir_e             dir_now, dir_snap;
   logic                 fin;
   logic [N*IDX_W-1:0]   rank_flat;

   arm_dir_hyst #(.CUR_W(CUR_W), .HYST(HYST)) u_dir (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_cur (arm_cur),
      .dir     (dir_now)
   );

   soc_rank_sorter #(.N(N), .SOC_W(SOC_W), .IDX_W(IDX_W)) u_sort (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .dir_in    (dir_now),
      .soc_flat  (soc_in),
      .busy      (busy),
      .fin       (fin),
      .dir_snap  (dir_snap),
      .rank_flat (rank_flat)
   );

   carrier_map_reg #(.N(N), .IDX_W(IDX_W)) u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .fin       (fin),
      .dir       (dir_snap),
      .rank_flat (rank_flat),
      .done      (done),
      .map_flat  (carrier_map)
   );

   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/soc_carrier_ranker_tb.sv
module soc_carrier_ranker_tb;
   localparam int N = 4;
   localparam int SW = 16;
   localparam int IW = 2;
   localparam int STEPS = N * (N - 1) / 2;
   localparam int HY = 64;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [N*SW-1:0]    soc_in = '0;
   logic signed [15:0] arm_cur = '0;
   logic               busy, done;
   logic [N*IW-1:0]    carrier_map;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   soc_carrier_ranker u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .soc_in(soc_in),
      .arm_cur(arm_cur), .busy(busy), .done(done), .carrier_map(carrier_map)
   );

   // behavioural reference
   bit          m_busy = 0, m_done = 0, m_dir = 1;
   int          m_cnt = 0;
   logic [7:0]  m_map = 8'hE4, m_pend = 8'hE4;

   function automatic logic [7:0] ref_map(input logic [N*SW-1:0] s, input bit dlv);
      int order[$];
      bit used[N];
      logic [7:0] r;
      for (int i = 0; i < N; i++) used[i] = 0;
      for (int k = 0; k < N; k++) begin
         int best = -1;
         for (int i = 0; i < N; i++)
            if (!used[i] && (best < 0 || s[i*SW +: SW] > s[best*SW +: SW])) best = i;
         used[best] = 1;
         order.push_back(best);
      end
      r = '0;
      for (int c = 0; c < N; c++)
         r[c*IW +: IW] = 2'(dlv ? order[c] : order[N-1-c]);
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_dir = 1; m_cnt = 0; m_map = 8'hE4;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == STEPS + 1) begin
               m_busy = 0; m_done = 1; m_map = m_pend;
            end
         end else if (start) begin
            m_busy = 1; m_cnt = 0; m_pend = ref_map(soc_in, m_dir);
         end
         if (arm_cur > HY) m_dir = 1;
         else if (arm_cur < -HY) m_dir = 0;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check(done === m_done, "R2", int'(done), int'(m_done));
         check(busy === m_busy, "R3", int'(busy), int'(m_busy));
         check(carrier_map === m_map, tag, int'(carrier_map), int'(m_map));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=<50000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic [15:0] pct(input int p);
      return 16'(p * 256);
   endfunction

   task automatic run(input logic [N*SW-1:0] s, input logic signed [15:0] cur,
                      input string t, input logic [7:0] exp, input bit disturb);
      int dn = 0;
      tag = t;
      @(negedge clk);
      arm_cur = cur;
      repeat (3) @(negedge clk);
      soc_in = s;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (disturb) begin
         @(negedge clk);
         soc_in = {N{pct(33)}};
         arm_cur = -16'sd900;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      for (int w = 0; w < 40; w++) begin
         @(negedge clk);
         if (done) dn++;
         if (dn == 1 && w < 39 && !done && dn == 1) ;
      end
      check(carrier_map === exp, t, int'(carrier_map), int'(exp));
      check(dn == 1, "R3", dn, 1);
   endtask

   logic [N*SW-1:0] sa, seq, spt, sbig;

   initial begin
      sa   = {pct(65), pct(20), pct(80), pct(50)};
      seq  = {N{pct(42)}};
      spt  = {pct(70), pct(40), pct(70), pct(40)};
      sbig = {16'h7FFF, 16'h8000, 16'h0100, 16'hFF00};
      repeat (3) @(negedge clk);
      // R1 reset state
      check(done === 1'b0, "R1", int'(done), 0);
      check(busy === 1'b0, "R1", int'(busy), 0);
      check(carrier_map === 8'hE4, "R1", int'(carrier_map), 8'hE4);
      rst_n = 1'b1;
      // R4 delivering, distinct values
      run(sa, 16'sd500, "R4", 8'h8D, 0);
      // R5 absorbing, mirrored
      run(sa, -16'sd500, "R5", 8'h72, 0);
      // R6 ties
      run(seq, -16'sd500, "R6", 8'h1B, 0);
      run(seq, 16'sd500, "R6", 8'hE4, 0);
      run(spt, 16'sd500, "R6", 8'h8D, 0);
      // R7 hysteresis: in band after delivering keeps delivering
      run(sa, -16'sd30, "R7", 8'h8D, 0);
      run(sa, -16'sd65, "R7", 8'h72, 0);
      run(sa, 16'sd64, "R7", 8'h72, 0);
      run(sa, 16'sd65, "R7", 8'h8D, 0);
      // R9 and R3: changes and a second start during the sort are ignored
      run(sa, 16'sd500, "R9", 8'h8D, 1);
      // R10 unsigned compare of full-range words
      run(sbig, 16'sd500, "R10", 8'h78, 0);
      run(sbig, -16'sd500, "R10", 8'h2D, 0);
      // R8 map stays a permutation
      begin
         bit [3:0] sn = '0;
         for (int c = 0; c < N; c++) sn[carrier_map[c*IW +: IW]] = 1'b1;
         check(sn == 4'hF, "R8", int'(sn), 4'hF);
      end
      repeat (5) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule